// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves a 36-bit word between two ports in both directions. Each direction has one storage element, and its latch-enable and capture clock set how that element behaves. With the latch-enable high, the element is a transparent latch. With the latch-enable low and the capture clock steady, it holds its value. With the latch-enable low, a rising capture clock makes it an edge-triggered register. The two directions work independently. Each direction has its own drive enable for its destination port. The A-to-B enable is active high and the B-to-A enable is active low.

Inside the chip the block runs on one system clock. The two capture clocks are sampled as ordinary inputs, and a rise is detected between two consecutive system-clock samples. The transparent path is combinational, from the source input to the destination output. Each port's output is given as a data vector and a separate drive flag, so a pad ring or bus fabric can build the tri-state buffer. While the latch-enable is high, the stored word tracks the input on every system-clock edge.

Top module: `xcvr_transceiver`

## Requirements
- R1: While `leAb` is 1, `bOut` equals `aIn` in the same cycle.
- R2: While `leAb` is 0 and `capClkAb` does not go from 0 to 1 between two system-clock samples, `bOut` keeps the stored word whatever `aIn` does.
- R3: When `leAb` is 0 and `capClkAb` is sampled 1 at a system-clock edge after being sampled 0 at the edge before, `aIn` is stored at that edge and appears on `bOut` right after it.
- R4: A falling `capClkAb` stores nothing.
- R5: After `leAb` has been 1 for at least one system-clock edge, dropping it to 0 leaves `bOut` at the last word that passed through, including when `capClkAb` rose while `leAb` was 1.
- R6: `bDrive` is 1 exactly when `oeAb` is 1; when `oeAb` is 0, port B is released.
- R7: `aDrive` is 1 exactly when `oeBaN` is 0; when `oeBaN` is 1, port A is released.
- R8: The B-to-A direction (`bIn`, `leBa`, `capClkBa`, `aOut`) follows the same transparent, hold, capture and tracking rules as A-to-B.
- R9: Toggling either output enable never changes either stored word.
- R10: Reset (active-low `rstN`) clears both stored words to zero.
- R11: Activity in one direction never changes the stored word of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aIn | input | 36 | Word arriving on port A |
| bIn | input | 36 | Word arriving on port B |
| leAb | input | 1 | A-to-B transparent enable |
| capClkAb | input | 1 | A-to-B capture clock (sampled) |
| oeAb | input | 1 | Port B drive enable, active high |
| leBa | input | 1 | B-to-A transparent enable |
| capClkBa | input | 1 | B-to-A capture clock (sampled) |
| oeBaN | input | 1 | Port A drive enable, active low |
| bOut | output | 36 | Word presented on port B |
| bDrive | output | 1 | Port B driver on |
| aOut | output | 36 | Word presented on port A |
| aDrive | output | 1 | Port A driver on |

## Verification
The bench targets the capture point, because a design that stores on a level, or on the falling edge, would show the new word too early or at the wrong transition. It holds the capture clock high for several cycles while the input changes. A design that re-captures while the clock stays high would drift in that window. It raises the capture clock while the latch-enable is high and then drops the enable; a design that treats that rise as pending would overwrite the tracked word. It toggles both output-enable polarities around stored data and resets in mid-stream. This exposes an inverted enable, an enable that corrupts storage, and a reset that misses one lane.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // strobes from control to datapath, one pass and one capture per direction
  typedef struct packed {
    logic [NUM_DIR-1:0] pass;
    logic [NUM_DIR-1:0] capt;
  } strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    leAb,
  input  logic    capClkAb,
  input  logic    oeAb,
  input  logic    leBa,
  input  logic    capClkBa,
  input  logic    oeBaN,
  output strobe_t strb,
  output logic    bDrive,
  output logic    aDrive
);
  logic [NUM_DIR-1:0] leVec;
  logic [NUM_DIR-1:0] ckVec;
  logic [NUM_DIR-1:0] ckPrev;

  assign leVec = {leBa, leAb};
  assign ckVec = {capClkBa, capClkAb};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (!rstN) ckPrev[d] <= 1'b0;
      else       ckPrev[d] <= ckVec[d];
    end
    assign strb.pass[d] = leVec[d];
    // a capture only counts while the element is not transparent
    assign strb.capt[d] = !leVec[d] && ckVec[d] && !ckPrev[d];
  end

  assign bDrive = oeAb;
  assign aDrive = !oeBaN;
endmodule

// File: rtl/xcvr_dpath.sv
module xcvr_dpath
  import xcvr_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic [W-1:0] aOut
);
  logic [W-1:0] srcVec [NUM_DIR];
  logic [W-1:0] dstVec [NUM_DIR];
  logic [W-1:0] store  [NUM_DIR];

  assign srcVec[DIR_AB] = aIn;
  assign srcVec[DIR_BA] = bIn;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        store[d] <= '0;
      else if (strb.pass[d] || strb.capt[d])
        store[d] <= srcVec[d];
    end
    assign dstVec[d] = strb.pass[d] ? srcVec[d] : store[d];
  end

  assign bOut = dstVec[DIR_AB];
  assign aOut = dstVec[DIR_BA];
endmodule

// File: rtl/xcvr_transceiver.sv
module xcvr_transceiver
  import xcvr_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         leAb,
  input  logic         capClkAb,
  input  logic         oeAb,
  input  logic         leBa,
  input  logic         capClkBa,
  input  logic         oeBaN,
  output logic [W-1:0] bOut,
  output logic         bDrive,
  output logic [W-1:0] aOut,
  output logic         aDrive
);
  strobe_t strb;

  xcvr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .leAb(leAb), .capClkAb(capClkAb), .oeAb(oeAb),
    .leBa(leBa), .capClkBa(capClkBa), .oeBaN(oeBaN),
    .strb(strb), .bDrive(bDrive), .aDrive(aDrive)
  );

  xcvr_dpath #(.W(W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .aIn(aIn), .bIn(bIn), .bOut(bOut), .aOut(aOut)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic         leAb,
  input logic         capClkAb,
  input logic         oeAb,
  input logic         leBa,
  input logic         capClkBa,
  input logic         oeBaN,
  input logic [W-1:0] bOut,
  input logic         bDrive,
  input logic [W-1:0] aOut,
  input logic         aDrive
);
  a_r1_ab_transparent: assert property (@(posedge clk) disable iff (!rstN)
    leAb |-> bOut == aIn);

  a_r8_ba_transparent: assert property (@(posedge clk) disable iff (!rstN)
    leBa |-> aOut == bIn);

  a_r2_ab_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leAb && !(capClkAb && !$past(capClkAb))) ##1 !leAb |-> $stable(bOut));

  a_r8_ba_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leBa && !(capClkBa && !$past(capClkBa))) ##1 !leBa |-> $stable(aOut));

  a_r3_ab_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leAb && capClkAb && !$past(capClkAb)) ##1 !leAb |-> bOut == $past(aIn));

  a_r8_ba_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !leBa && capClkBa && !$past(capClkBa)) ##1 !leBa |-> aOut == $past(bIn));

  a_r6_b_drive: assert property (@(posedge clk) disable iff (!rstN)
    bDrive == oeAb);

  a_r7_a_drive: assert property (@(posedge clk) disable iff (!rstN)
    aDrive == !oeBaN);
endmodule

bind xcvr_transceiver xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
  .leAb(leAb), .capClkAb(capClkAb), .oeAb(oeAb),
  .leBa(leBa), .capClkBa(capClkBa), .oeBaN(oeBaN),
  .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
);

// File: tb/sim_xcvr_transceiver.sv
module sim_xcvr_transceiver;
  localparam int W = 36;

  typedef struct packed {
    logic         leAb, ckAb, oeAb;
    logic [W-1:0] a;
    logic         leBa, ckBa, oeBaN;
    logic [W-1:0] b;
    logic [W-1:0] expB;
    logic         expBDrv;
    logic [W-1:0] expA;
    logic         expADrv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    // v0 R10: stores zero after reset, le low
    '{1'b0,1'b0,1'b0,36'h000000111, 1'b0,1'b0,1'b1,36'h000000222, 36'h0,1'b0, 36'h0,1'b0},
    // v1 R1 R6: transparent A->B, B driven
    '{1'b1,1'b0,1'b1,36'h123456789, 1'b0,1'b0,1'b1,36'h000000222, 36'h123456789,1'b1, 36'h0,1'b0},
    // v2 R5: drop le, keep last passed word
    '{1'b0,1'b0,1'b1,36'hF0F0F0F0F, 1'b0,1'b0,1'b1,36'h000000222, 36'h123456789,1'b1, 36'h0,1'b0},
    // v3 R3: rising capture clock stores A
    '{1'b0,1'b1,1'b1,36'hABCDE1234, 1'b0,1'b0,1'b1,36'h000000222, 36'hABCDE1234,1'b1, 36'h0,1'b0},
    // v4 R2: clock held high, no re-capture
    '{1'b0,1'b1,1'b1,36'h000000FFF, 1'b0,1'b0,1'b1,36'h000000222, 36'hABCDE1234,1'b1, 36'h0,1'b0},
    // v5 R4: falling edge stores nothing
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b0,1'b1,36'h000000222, 36'hABCDE1234,1'b1, 36'h0,1'b0},
    // v6 R6 R9: B released, content kept
    '{1'b0,1'b0,1'b0,36'h555555555, 1'b0,1'b0,1'b1,36'h000000222, 36'hABCDE1234,1'b0, 36'h0,1'b0},
    // v7 R9: B driven again, same content
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b0,1'b1,36'h000000222, 36'hABCDE1234,1'b1, 36'h0,1'b0},
    // v8 R8 R7: transparent B->A, A driven
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b1,1'b0,1'b0,36'h987654321, 36'hABCDE1234,1'b1, 36'h987654321,1'b1},
    // v9 R8: tracking hold on B->A
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b0,1'b0,36'h0FF00FF00, 36'hABCDE1234,1'b1, 36'h987654321,1'b1},
    // v10 R8: capture on B->A
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b1,1'b0,36'h13579BDF0, 36'hABCDE1234,1'b1, 36'h13579BDF0,1'b1},
    // v11 R8: clock held high on B->A
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b1,1'b0,36'h222222222, 36'hABCDE1234,1'b1, 36'h13579BDF0,1'b1},
    // v12 R7 R9: A released, content kept
    '{1'b0,1'b0,1'b1,36'h555555555, 1'b0,1'b0,1'b1,36'h222222222, 36'hABCDE1234,1'b1, 36'h13579BDF0,1'b0},
    // v13 R11: A->B transparent while B->A captures
    '{1'b1,1'b0,1'b1,36'h0A0A0A0A0, 1'b0,1'b1,1'b0,36'h0B0B0B0B0, 36'h0A0A0A0A0,1'b1, 36'h0B0B0B0B0,1'b1},
    // v14 R5: capture clock rises while le high
    '{1'b1,1'b1,1'b1,36'h0C0C0C0C0, 1'b0,1'b1,1'b0,36'h0D0D0D0D0, 36'h0C0C0C0C0,1'b1, 36'h0B0B0B0B0,1'b1},
    // v15 R5: le low, clock still high: tracked word kept
    '{1'b0,1'b1,1'b1,36'h0E0E0E0E0, 1'b0,1'b1,1'b0,36'h0F0F0F0F0, 36'h0C0C0C0C0,1'b1, 36'h0B0B0B0B0,1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic leAb = 1'b0, capClkAb = 1'b0, oeAb = 1'b0;
  logic leBa = 1'b0, capClkBa = 1'b0, oeBaN = 1'b1;
  logic [W-1:0] bOut, aOut;
  logic bDrive, aDrive;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  xcvr_transceiver #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .aIn(aIn), .bIn(bIn),
    .leAb(leAb), .capClkAb(capClkAb), .oeAb(oeAb),
    .leBa(leBa), .capClkBa(capClkBa), .oeBaN(oeBaN),
    .bOut(bOut), .bDrive(bDrive), .aOut(aOut), .aDrive(aDrive)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    leAb = v.leAb; capClkAb = v.ckAb; oeAb = v.oeAb; aIn = v.a;
    leBa = v.leBa; capClkBa = v.ckBa; oeBaN = v.oeBaN; bIn = v.b;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R10 reset state at ports
    @(negedge clk);
    chk("R10 bOut reset", bOut, '0);
    chk("R10 aOut reset", aOut, '0);
    chk("R6 bDrive reset", {35'b0, bDrive}, 36'd0);
    chk("R7 aDrive reset", {35'b0, aDrive}, 36'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(posedge clk);
      #1;
      chk($sformatf("R1-vec%0d bOut", i), bOut, TBL[i].expB);
      chk($sformatf("R6 vec%0d bDrive", i), {35'b0, bDrive}, {35'b0, TBL[i].expBDrv});
      chk($sformatf("R8 vec%0d aOut", i), aOut, TBL[i].expA);
      chk($sformatf("R7 vec%0d aDrive", i), {35'b0, aDrive}, {35'b0, TBL[i].expADrv});
    end

    // R3 exact capture cycle: new word not visible before the system edge
    @(negedge clk);
    leAb = 1'b0; capClkAb = 1'b0; leBa = 1'b0; capClkBa = 1'b0;
    @(negedge clk);
    aIn = 36'h777777777; capClkAb = 1'b1;
    #1 chk("R3 before edge", bOut, 36'h0C0C0C0C0);
    @(posedge clk); #1;
    chk("R3 after edge", bOut, 36'h777777777);
    chk("R11 other lane untouched", aOut, 36'h0B0B0B0B0);

    // R10 reset mid-stream clears both lanes
    @(negedge clk);
    rstN = 1'b0; capClkAb = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 bOut cleared", bOut, '0);
    chk("R10 aOut cleared", aOut, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule